// File: doc/BRIEF.md
# Thermal Sprint-and-Rest Governor

This block picks the power mode of a small multicore one clock at a time. It drives a core-enable mask and a frequency-select bit. Three operating points are possible. The sustainable point runs core 0 at base frequency and may run forever. The parallel sprint runs every core at base frequency. The boosted sprint runs every core at twice base frequency. When work arrives, the governor grants a sprint. The sprint ends when the die-temperature code reaches a programmed ceiling, when its safe time budget runs out, or when the task completes. If the task completes during a sprint, the chip drops straight to idle (all cores off) and does not return to the sustainable point.

For long jobs a cyclic schedule repeats a fixed sprint phase and a fixed rest phase (all cores off). The governor checks continuously, with integer arithmetic, that the programmed sprint fraction keeps average power at or below the sustainable limit. It reports a configuration error when it does not, and it refuses cyclic sprinting while that error is present. Durations are counted in ticks of a prescaled time base. After a temperature abort, a re-arm threshold adds hysteresis.

Top module: `sprint_governor`

## Requirements
- R1: Outputs take only these encodings. Idle: mask 0000, freq_hi 0. Sustainable: mask 0001, freq_hi 0. Parallel sprint: mask 1111, freq_hi 0. Boosted sprint: mask 1111, freq_hi 1. freq_hi is never 1 unless every core is enabled. Mask and frequency change on the same clock edge.
- R2: A synchronous reset forces the idle outputs and clears config_error.
- R3: In idle, work_pending=1 with task_done=0 changes the outputs one clock later. mode_sel[0] selects the sprint type (0 parallel, 1 boosted) and mode_sel[1] selects the schedule (0 one-shot, 1 cyclic). A sprint is granted only when the governor is armed, temp_code < temp_max, and (for the cyclic schedule) config_error=0. Otherwise the sustainable point is entered.
- R4: A one-shot sprint that is not stopped lasts exactly L*TICK_DIV clocks and then falls back to the sustainable point. L is the clipped sprint length.
- R5: While sprinting, temp_code >= temp_max with no task_done puts the outputs at the sustainable point on the next clock. They stay there until task_done.
- R6: task_done during a sprint gives idle outputs on the next clock.
- R7: In the cyclic schedule, each sprint phase is followed by a rest phase with mask 0000 lasting rest_len*TICK_DIV clocks. At the end of the rest the governor sprints again if work_pending=1, otherwise it goes idle. task_done during a rest returns it to idle.
- R8: The sprint length used is min(sprint_len, cap). The cap is MAX_PAR_TICKS for a parallel sprint and MAX_BOOST_TICKS for a boosted sprint.
- R9: config_error, updated one clock after its inputs, is 1 exactly when any of the following holds. The power used for P_sp is p_parallel or p_boost, chosen by mode_sel[0]; the sprint length used is the clipped one.
  - p_sustain <= p_idle
  - P_sp <= p_sustain
  - Lclip*(P_sp - p_idle) > (Lclip + rest_len)*(p_sustain - p_idle)
- R10: When config_error=1, a cyclic start enters the sustainable point instead of sprinting.
- R11: After a temperature abort, no sprint is granted until temp_code < temp_rearm has been seen on a clock edge.
- R12: Sprint type and schedule are latched only when leaving idle. A change of mode_sel mid-phase does not alter the outputs of the current or later phases of that job.
- R13: task_done at the sustainable point gives idle outputs on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| work_pending | input | 1 | Work is waiting |
| task_done | input | 1 | Current task has finished |
| temp_code | input | TEMP_W | Digitized die temperature |
| temp_max | input | TEMP_W | Sprint abort threshold |
| temp_rearm | input | TEMP_W | Re-arm threshold after an abort |
| mode_sel | input | 2 | [0] sprint type, [1] schedule |
| sprint_len | input | DUR_W | Sprint phase length in ticks |
| rest_len | input | DUR_W | Rest phase length in ticks |
| p_sustain | input | PWR_W | Sustainable power limit, watts |
| p_idle | input | PWR_W | Idle power, watts |
| p_parallel | input | PWR_W | Parallel sprint power, watts |
| p_boost | input | PWR_W | Boosted sprint power, watts |
| core_mask | output | N_CORES | Core enable mask |
| freq_hi | output | 1 | 1 selects double base frequency |
| config_error | output | 1 | Programmed duty cycle is not sustainable |

## Verification
The bench probes the points where a sprint ends. These are the last clock of the timed phase, the clipped boosted budget, and a mid-sprint temperature abort. A timer off by one tick, or one that ignores the cap, moves the fall-back edge and is caught. The duty check is driven exactly at equality and one step on either side, with lengths that pass only when clipped. A strict comparison, or a check on the unclipped length, flips config_error. Hysteresis is checked by restarting while still warm, where a design that re-arms on the ceiling alone would sprint. Mode latching is checked by changing mode_sel mid-cycle and by leaving a rest early, which shows whether idle was really reached.

// File: rtl/sprint_gov_pkg.sv
package sprint_gov_pkg;

   typedef enum logic [1:0] {
      GS_IDLE    = 2'd0,
      GS_SUSTAIN = 2'd1,
      GS_SPRINT  = 2'd2,
      GS_REST    = 2'd3
   } gov_state_t;

   // schedule bit positions inside mode_sel
   localparam int MS_KIND  = 0;
   localparam int MS_CYCLE = 1;

endpackage

// File: rtl/sg_phase_timer.sv
module sg_phase_timer #(
   parameter int TICK_DIV = 4,
   parameter int DUR_W    = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic [DUR_W-1:0] len,
   output logic             done
);
   logic             tick;
   logic [DUR_W-1:0] tick_cnt;

   generate
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(TICK_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] div_cnt;
         always_ff @(posedge clk) begin
            if (rst || restart)          div_cnt <= '0;
            else if (div_cnt == DIV_LAST) div_cnt <= '0;
            else                          div_cnt <= div_cnt + 1'b1;
         end
         assign tick = (div_cnt == DIV_LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || restart) tick_cnt <= '0;
      else if (tick)      tick_cnt <= tick_cnt + 1'b1;
   end

   // phase ends on the tick that completes len ticks (len 0 acts as 1)
   assign done = tick && (({1'b0, tick_cnt} + 1'b1) >= {1'b0, len});

endmodule

// File: rtl/sg_duty_check.sv
module sg_duty_check #(
   parameter int DUR_W = 8,
   parameter int PWR_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DUR_W-1:0] run_len,
   input  logic [DUR_W-1:0] rest_len,
   input  logic [PWR_W-1:0] p_sus,
   input  logic [PWR_W-1:0] p_idle,
   input  logic [PWR_W-1:0] p_run,
   output logic             bad
);
   localparam int PROD_W = DUR_W + 1 + PWR_W;

   logic              order_ok;
   logic [PWR_W-1:0]  run_head;
   logic [PWR_W-1:0]  sus_head;
   logic [DUR_W:0]    period;
   logic [PROD_W-1:0] lhs;
   logic [PROD_W-1:0] rhs;

   always_comb begin
      order_ok = (p_sus > p_idle) && (p_run > p_sus);
      run_head = p_run - p_idle;
      sus_head = p_sus - p_idle;
      period   = {1'b0, run_len} + {1'b0, rest_len};
      lhs      = PROD_W'(run_len) * PROD_W'(run_head);
      rhs      = PROD_W'(period)  * PROD_W'(sus_head);
   end

   always_ff @(posedge clk) begin
      if (rst) bad <= 1'b0;
      else     bad <= !(order_ok && (lhs <= rhs));
   end

endmodule

// File: rtl/sg_gov_fsm.sv
module sg_gov_fsm
   import sprint_gov_pkg::*;
#(
   parameter int N_CORES = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               work_pending,
   input  logic               task_done,
   input  logic               hot,
   input  logic               cool,
   input  logic [1:0]         mode_sel,
   input  logic               cfg_bad,
   input  logic               phase_done,
   output logic               restart,
   output logic               kind_q,
   output logic               in_sprint,
   output logic [N_CORES-1:0] core_mask,
   output logic               freq_hi
);
   localparam logic [N_CORES-1:0] MASK_ALL = '1;
   localparam logic [N_CORES-1:0] MASK_ONE = N_CORES'(1);

   gov_state_t state, state_nx;
   logic       armed, armed_nx;
   logic       cyc_q, cyc_nx, kind_nx;

   always_comb begin
      state_nx = state;
      kind_nx  = kind_q;
      cyc_nx   = cyc_q;
      unique case (state)
         GS_IDLE: begin
            if (work_pending && !task_done) begin
               kind_nx = mode_sel[MS_KIND];
               cyc_nx  = mode_sel[MS_CYCLE];
               if (armed && !hot && !(mode_sel[MS_CYCLE] && cfg_bad))
                  state_nx = GS_SPRINT;
               else
                  state_nx = GS_SUSTAIN;
            end
         end
         GS_SUSTAIN: if (task_done) state_nx = GS_IDLE;
         GS_SPRINT: begin
            if (task_done)       state_nx = GS_IDLE;
            else if (hot)        state_nx = GS_SUSTAIN;
            else if (phase_done) state_nx = cyc_q ? GS_REST : GS_SUSTAIN;
         end
         GS_REST: begin
            if (task_done)          state_nx = GS_IDLE;
            else if (phase_done) begin
               if (!work_pending)   state_nx = GS_IDLE;
               else if (hot)        state_nx = GS_SUSTAIN;
               else                 state_nx = GS_SPRINT;
            end
         end
         default: state_nx = GS_IDLE;
      endcase

      if (state == GS_SPRINT && hot && !task_done) armed_nx = 1'b0;
      else if (cool)                               armed_nx = 1'b1;
      else                                         armed_nx = armed;
   end

   assign restart   = (state_nx != state);
   assign in_sprint = (state == GS_SPRINT);

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= GS_IDLE;
         armed     <= 1'b1;
         kind_q    <= 1'b0;
         cyc_q     <= 1'b0;
         core_mask <= '0;
         freq_hi   <= 1'b0;
      end else begin
         state  <= state_nx;
         armed  <= armed_nx;
         kind_q <= kind_nx;
         cyc_q  <= cyc_nx;
         unique case (state_nx)
            GS_SPRINT:  core_mask <= MASK_ALL;
            GS_SUSTAIN: core_mask <= MASK_ONE;
            default:    core_mask <= '0;
         endcase
         freq_hi <= (state_nx == GS_SPRINT) && kind_nx;
      end
   end

endmodule

// File: rtl/sprint_governor.sv
module sprint_governor #(
   parameter int N_CORES         = 4,
   parameter int TEMP_W          = 8,
   parameter int DUR_W           = 8,
   parameter int PWR_W           = 8,
   parameter int TICK_DIV        = 4,
   parameter int MAX_PAR_TICKS   = 20,
   parameter int MAX_BOOST_TICKS = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               work_pending,
   input  logic               task_done,
   input  logic [TEMP_W-1:0]  temp_code,
   input  logic [TEMP_W-1:0]  temp_max,
   input  logic [TEMP_W-1:0]  temp_rearm,
   input  logic [1:0]         mode_sel,
   input  logic [DUR_W-1:0]   sprint_len,
   input  logic [DUR_W-1:0]   rest_len,
   input  logic [PWR_W-1:0]   p_sustain,
   input  logic [PWR_W-1:0]   p_idle,
   input  logic [PWR_W-1:0]   p_parallel,
   input  logic [PWR_W-1:0]   p_boost,
   output logic [N_CORES-1:0] core_mask,
   output logic               freq_hi,
   output logic               config_error
);
   localparam logic [DUR_W-1:0] CAP_PAR   = DUR_W'(MAX_PAR_TICKS);
   localparam logic [DUR_W-1:0] CAP_BOOST = DUR_W'(MAX_BOOST_TICKS);

   generate
      if (N_CORES < 2) begin : g_bad_cores
         $error("sprint_governor: N_CORES must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("sprint_governor: TICK_DIV must be at least 1");
      end
      if (MAX_PAR_TICKS < 1 || MAX_PAR_TICKS >= (1 << DUR_W) ||
          MAX_BOOST_TICKS < 1 || MAX_BOOST_TICKS >= (1 << DUR_W)) begin : g_bad_cap
         $error("sprint_governor: sprint caps must fit DUR_W and be nonzero");
      end
   endgenerate

   logic             hot, cool;
   logic             restart, kind_q, in_sprint, phase_done;
   logic [DUR_W-1:0] run_clip, cfg_clip, phase_len;

   assign hot  = (temp_code >= temp_max);
   assign cool = (temp_code <  temp_rearm);

   // budget of the sprint in progress (latched type) and of the programmed one
   assign run_clip  = (sprint_len > (kind_q ? CAP_BOOST : CAP_PAR))
                      ? (kind_q ? CAP_BOOST : CAP_PAR) : sprint_len;
   assign cfg_clip  = (sprint_len > (mode_sel[0] ? CAP_BOOST : CAP_PAR))
                      ? (mode_sel[0] ? CAP_BOOST : CAP_PAR) : sprint_len;
   assign phase_len = in_sprint ? run_clip : rest_len;

   sg_phase_timer #(.TICK_DIV(TICK_DIV), .DUR_W(DUR_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .len     (phase_len),
      .done    (phase_done)
   );

   sg_duty_check #(.DUR_W(DUR_W), .PWR_W(PWR_W)) u_duty (
      .clk      (clk),
      .rst      (rst),
      .run_len  (cfg_clip),
      .rest_len (rest_len),
      .p_sus    (p_sustain),
      .p_idle   (p_idle),
      .p_run    (mode_sel[0] ? p_boost : p_parallel),
      .bad      (config_error)
   );

   sg_gov_fsm #(.N_CORES(N_CORES)) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .work_pending (work_pending),
      .task_done    (task_done),
      .hot          (hot),
      .cool         (cool),
      .mode_sel     (mode_sel),
      .cfg_bad      (config_error),
      .phase_done   (phase_done),
      .restart      (restart),
      .kind_q       (kind_q),
      .in_sprint    (in_sprint),
      .core_mask    (core_mask),
      .freq_hi      (freq_hi)
   );

endmodule

// File: rtl/sprint_governor_chk.sv
module sprint_governor_chk #(
   parameter int N_CORES         = 4,
   parameter int TEMP_W          = 8,
   parameter int TICK_DIV        = 4,
   parameter int MAX_PAR_TICKS   = 20,
   parameter int MAX_BOOST_TICKS = 3
) (
   input logic               clk,
   input logic               rst,
   input logic               task_done,
   input logic [TEMP_W-1:0]  temp_code,
   input logic [TEMP_W-1:0]  temp_max,
   input logic [N_CORES-1:0] core_mask,
   input logic               freq_hi
);
   localparam logic [N_CORES-1:0] ALL = '1;
   localparam logic [N_CORES-1:0] ONE = N_CORES'(1);
   localparam int LIM_PAR   = MAX_PAR_TICKS * TICK_DIV;
   localparam int LIM_BOOST = MAX_BOOST_TICKS * TICK_DIV;

   int run_cnt;
   always_ff @(posedge clk) begin
      if (rst || core_mask != ALL) run_cnt <= 0;
      else if (run_cnt < LIM_PAR + LIM_BOOST) run_cnt <= run_cnt + 1;
   end

   // R1
   freq_link_chk: assert property (@(posedge clk) disable iff (rst)
      freq_hi |-> core_mask == ALL);

   // R1
   mask_legal_chk: assert property (@(posedge clk) disable iff (rst)
      (core_mask == '0) || (core_mask == ONE) || (core_mask == ALL));

   // R2
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (core_mask == '0 && !freq_hi));

   // R5
   hot_abort_chk: assert property (@(posedge clk) disable iff (rst)
      (core_mask == ALL && temp_code >= temp_max && !task_done) |=> core_mask == ONE);

   // R6
   sprint_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (core_mask == ALL && task_done) |=> core_mask == '0);

   // R13
   sustain_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (core_mask == ONE && task_done) |=> core_mask == '0);

   // R8
   sprint_cap_chk: assert property (@(posedge clk) disable iff (rst)
      core_mask == ALL |-> run_cnt < (freq_hi ? LIM_BOOST : LIM_PAR));

   // R12
   freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (core_mask == ALL && $past(core_mask) == ALL) |-> $stable(freq_hi));

endmodule

bind sprint_governor sprint_governor_chk #(
   .N_CORES         (N_CORES),
   .TEMP_W          (TEMP_W),
   .TICK_DIV        (TICK_DIV),
   .MAX_PAR_TICKS   (MAX_PAR_TICKS),
   .MAX_BOOST_TICKS (MAX_BOOST_TICKS)
) u_chk (.*);

// File: tb/sprint_governor_tb.sv
`timescale 1ns/1ps
module sprint_governor_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       work_pending = 1'b0, task_done = 1'b0;
   logic [7:0] temp_code = 8'd100, temp_max = 8'd200, temp_rearm = 8'd150;
   logic [1:0] mode_sel = 2'b00;
   logic [7:0] sprint_len = 8'd5, rest_len = 8'd10;
   logic [7:0] p_sustain = 8'd10, p_idle = 8'd5, p_parallel = 8'd20, p_boost = 8'd50;
   logic [3:0] core_mask;
   logic       freq_hi, config_error;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sprint_governor u_dut (
      .clk(clk), .rst(rst), .work_pending(work_pending), .task_done(task_done),
      .temp_code(temp_code), .temp_max(temp_max), .temp_rearm(temp_rearm),
      .mode_sel(mode_sel), .sprint_len(sprint_len), .rest_len(rest_len),
      .p_sustain(p_sustain), .p_idle(p_idle), .p_parallel(p_parallel),
      .p_boost(p_boost), .core_mask(core_mask), .freq_hi(freq_hi),
      .config_error(config_error)
   );

   typedef struct packed {
      logic       kind;
      logic [7:0] s, r, sus, idl, par, bst;
      logic       err;
   } duty_vec_t;

   // kind, sprint, rest, sustain, idle, parallel, boost, expected error
   localparam duty_vec_t DUTY [10] = '{
      '{1'b0, 8'd5,  8'd10, 8'd10, 8'd5, 8'd20, 8'd50, 1'b0},
      '{1'b0, 8'd5,  8'd9,  8'd10, 8'd5, 8'd20, 8'd50, 1'b1},
      '{1'b1, 8'd2,  8'd16, 8'd10, 8'd5, 8'd20, 8'd50, 1'b0},
      '{1'b1, 8'd2,  8'd15, 8'd10, 8'd5, 8'd20, 8'd50, 1'b1},
      '{1'b1, 8'd7,  8'd16, 8'd10, 8'd5, 8'd20, 8'd50, 1'b1},
      '{1'b1, 8'd7,  8'd24, 8'd10, 8'd5, 8'd20, 8'd50, 1'b0},
      '{1'b0, 8'd25, 8'd40, 8'd10, 8'd5, 8'd20, 8'd50, 1'b0},
      '{1'b0, 8'd20, 8'd39, 8'd10, 8'd5, 8'd20, 8'd50, 1'b1},
      '{1'b0, 8'd5,  8'd50, 8'd5,  8'd5, 8'd20, 8'd50, 1'b1},
      '{1'b0, 8'd5,  8'd50, 8'd10, 8'd5, 8'd10, 8'd50, 1'b1}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [3:0] m, input logic f);
      n_chk++;
      if (core_mask !== m || freq_hi !== f) begin
         n_fail++;
         $display("FAIL %s: mask=%b freq_hi=%b, expected mask=%b freq_hi=%b",
                  tag, core_mask, freq_hi, m, f);
      end
   endtask

   task automatic chk_err(input string tag, input logic e);
      n_chk++;
      if (config_error !== e) begin
         n_fail++;
         $display("FAIL %s: config_error=%b, expected %b", tag, config_error, e);
      end
   endtask

   task automatic finish_job();
      work_pending = 1'b0;
      task_done    = 1'b1;
      tick(1);
      task_done    = 1'b0;
      tick(1);
   endtask

   task automatic wrap_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R4 R7 timing): run still active, expected completion");
      wrap_up();
   end

   initial begin
      tick(3);
      rst = 1'b0;
      tick(1);
      chk("R2 reset idle", 4'b0000, 1'b0);
      chk_err("R2 reset clears error", 1'b0);

      // R9: duty-check vector table
      foreach (DUTY[i]) begin
         mode_sel   = {1'b0, DUTY[i].kind};
         sprint_len = DUTY[i].s;
         rest_len   = DUTY[i].r;
         p_sustain  = DUTY[i].sus;
         p_idle     = DUTY[i].idl;
         p_parallel = DUTY[i].par;
         p_boost    = DUTY[i].bst;
         tick(2);
         chk_err($sformatf("R9 duty vector %0d", i), DUTY[i].err);
      end
      p_sustain = 8'd10; p_idle = 8'd5; p_parallel = 8'd20; p_boost = 8'd50;

      // R4: one-shot parallel sprint runs out its timer
      mode_sel = 2'b00; sprint_len = 8'd5; rest_len = 8'd10;
      tick(2);
      work_pending = 1'b1;
      tick(1);  chk("R3 parallel grant", 4'b1111, 1'b0);
      tick(19); chk("R4 last sprint clock", 4'b1111, 1'b0);
      tick(1);  chk("R4 fall back to sustainable", 4'b0001, 1'b0);
      work_pending = 1'b0; task_done = 1'b1;
      tick(1);  chk("R13 sustainable to idle", 4'b0000, 1'b0);
      task_done = 1'b0;
      tick(1);

      // R8: boosted one-shot, programmed 7 clipped to 3 ticks
      mode_sel = 2'b01; sprint_len = 8'd7;
      work_pending = 1'b1;
      tick(1);  chk("R1 boosted grant", 4'b1111, 1'b1);
      tick(11); chk("R8 last clipped clock", 4'b1111, 1'b1);
      tick(1);  chk("R8 clipped end", 4'b0001, 1'b0);
      finish_job();

      // R5 / R11: temperature abort and hysteresis
      mode_sel = 2'b00; sprint_len = 8'd5;
      work_pending = 1'b1;
      tick(1);  chk("R3 grant before abort", 4'b1111, 1'b0);
      tick(3);
      temp_code = 8'd210;
      tick(1);  chk("R5 abort to sustainable", 4'b0001, 1'b0);
      temp_code = 8'd180;
      tick(30); chk("R5 stays sustainable", 4'b0001, 1'b0);
      finish_job();
      work_pending = 1'b1;
      tick(1);  chk("R11 warm restart not granted", 4'b0001, 1'b0);
      finish_job();
      temp_code = 8'd140;
      tick(2);
      work_pending = 1'b1;
      tick(1);  chk("R11 re-armed sprint", 4'b1111, 1'b0);
      finish_job();

      // R3: start while at the ceiling
      temp_code = 8'd200;
      work_pending = 1'b1;
      tick(1);  chk("R3 hot start sustainable", 4'b0001, 1'b0);
      finish_job();
      temp_code = 8'd100;
      tick(1);

      // R6: task done mid-sprint
      work_pending = 1'b1;
      tick(3);
      work_pending = 1'b0; task_done = 1'b1;
      tick(1);  chk("R6 sprint to idle", 4'b0000, 1'b0);
      task_done = 1'b0;
      tick(1);

      // R7 / R12: cyclic parallel schedule
      mode_sel = 2'b10; sprint_len = 8'd5; rest_len = 8'd10;
      tick(2);
      chk_err("R9 cyclic schedule legal", 1'b0);
      work_pending = 1'b1;
      tick(1);  chk("R7 first sprint", 4'b1111, 1'b0);
      tick(19); chk("R7 sprint last clock", 4'b1111, 1'b0);
      tick(1);  chk("R7 rest begins", 4'b0000, 1'b0);
      tick(39); chk("R7 rest last clock", 4'b0000, 1'b0);
      tick(1);  chk("R7 second sprint", 4'b1111, 1'b0);
      mode_sel = 2'b11;
      tick(1);  chk("R12 mid-phase mode change ignored", 4'b1111, 1'b0);
      tick(18); chk("R12 sprint keeps latched length", 4'b1111, 1'b0);
      tick(1);  chk("R12 rest still follows", 4'b0000, 1'b0);
      tick(5);
      work_pending = 1'b0; task_done = 1'b1;
      tick(1);
      task_done = 1'b0;
      mode_sel = 2'b00; work_pending = 1'b1;
      tick(1);  chk("R7 done in rest reached idle", 4'b1111, 1'b0);
      finish_job();

      // R10: cyclic start refused while duty check fails
      mode_sel = 2'b11;
      tick(2);
      chk_err("R9 boosted cyclic over budget", 1'b1);
      work_pending = 1'b1;
      tick(1);  chk("R10 refused cyclic sprint", 4'b0001, 1'b0);
      finish_job();

      // R2: reset in the middle of a sprint with an error flagged
      mode_sel = 2'b01;
      tick(2);
      work_pending = 1'b1;
      tick(1);  chk("R1 boosted one-shot despite error", 4'b1111, 1'b1);
      rst = 1'b1;
      tick(1);  chk("R2 mid-run reset idle", 4'b0000, 1'b0);
      chk_err("R2 mid-run reset error", 1'b0);
      work_pending = 1'b0;
      rst = 1'b0;
      tick(2);

      wrap_up();
   end
endmodule